// File: doc/BRIEF.md
# Descending Word Stack Engine

This block owns a hardware stack that lives in byte-addressed memory inside one 64 KB stack segment. A client sends push or pop commands, each carrying or returning one 16-bit word. The engine keeps the 16-bit stack pointer. It turns every command into two byte-wide memory cycles at the physical address (segment × 16 + offset). It returns one response per command. The stack grows toward lower addresses. A push moves the pointer down by two before it writes. A pop reads at the pointer and then moves it up by two. The pointer therefore always addresses the most recently stored word.

The command, memory and response paths are valid/ready streams. A command is taken only when `cmd_valid` and `cmd_ready` are both high at a rising edge. `cmd_ready` is high only while the engine is idle, so one command is in flight at a time. A memory beat completes on a rising edge where `mem_valid` and `mem_ready` are both high. Until that edge the request holds steady, and the memory may stall for any number of cycles. Read data on `mem_rdata` is taken in the completing cycle. A response stays presented, unchanged, until `rsp_ready` takes it, and the next command is not accepted before then. Wrapping past either end of the segment is reported in the response but does not stop the operation.

Top module: `stack_engine`

## Requirements
- R1: After reset the pointer `sp` is FFFEh (empty stack), `cmd_ready` is high, `busy` is low, and neither `mem_valid` nor `rsp_valid` is asserted.
- R2: `cmd_op` = 0 is a push. The pointer becomes the old value minus 2 in the cycle after acceptance. The word is then written at that new offset.
- R3: `cmd_op` = 1 is a pop. The word is read at the current offset. The pointer becomes the old value plus 2 once the last byte has been read. `rsp_data` returns {high byte, low byte}.
- R4: Every command makes exactly two memory beats, the low byte first at the word offset and the high byte at offset + 1. `mem_we` is 1 for a push and 0 for a pop. The low data byte (bits 7:0) travels at the lower address.
- R5: `mem_addr` equals `seg_base` × 16 plus the byte offset, truncated to 20 bits. The segment value is captured when the command is accepted.
- R6: While a command is in flight (`busy` high), `cmd_ready` is low and no further command is taken.
- R7: While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` keep their values on the next cycle.
- R8: While `rsp_valid` is high and `rsp_ready` is low, the response stays valid with `rsp_data`, `rsp_ovf` and `rsp_unf` unchanged.
- R9: A pop accepted with `sp` = FFFEh sets `rsp_unf`. The pointer still wraps to 0000h, and the bytes come from offsets FFFEh and FFFFh.
- R10: A push accepted with `sp` = 0000h sets `rsp_ovf`. The pointer still wraps to FFFEh, and the word is written there. Both flags are 0 for every other command.
- R11: The response to a push echoes the pushed word on `rsp_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| seg_base | input | 16 | Stack segment value, sampled at command acceptance |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_op | input | 1 | 0 = push, 1 = pop |
| cmd_data | input | 16 | Word to push |
| mem_valid | output | 1 | Byte memory cycle requested |
| mem_ready | input | 1 | Memory completes the cycle this clock |
| mem_we | output | 1 | 1 = write byte, 0 = read byte |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid in the completing cycle |
| rsp_valid | output | 1 | Command done, response presented |
| rsp_ready | input | 1 | Client takes the response |
| rsp_data | output | 16 | Popped word, or pushed word echoed |
| rsp_ovf | output | 1 | Push wrapped below offset 0 |
| rsp_unf | output | 1 | Pop taken from an empty stack |
| busy | output | 1 | Command in flight |
| sp | output | 16 | Current stack pointer |

## Verification
Long random push/pop runs with stalls on the memory and response streams check last-in-first-out ordering against a model memory. They also check that each byte lands at the right address under back-pressure. Directed sequences start from the empty stack: a pop first, which must underflow and wrap, then a push at 0000h, which must overflow back to FFFEh. These separate the two boundary flags from the ordinary pointer arithmetic. A segment of FFFFh checks that the physical address truncates to 20 bits instead of carrying. A few changes of segment mid-run check that the segment is captured per command.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic {
    OP_PUSH = 1'b0,
    OP_POP  = 1'b1
  } stk_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_RSP  = 2'd2
  } stk_state_e;
endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int PTR_W = 16,
  parameter int STEP = 2,
  parameter logic [PTR_W-1:0] PTR_INIT = 16'hFFFE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_en,
  input  logic             inc_en,
  output logic [PTR_W-1:0] sp,
  output logic             at_empty,
  output logic             at_floor
);
  localparam logic [PTR_W-1:0] STEP_V = PTR_W'(STEP);

  logic [PTR_W-1:0] sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= PTR_INIT;
    end else if (dec_en) begin
      sp_q <= sp_q - STEP_V;
    end else if (inc_en) begin
      sp_q <= sp_q + STEP_V;
    end
  end

  assign sp       = sp_q;
  assign at_empty = (sp_q == PTR_INIT);
  assign at_floor = (sp_q == '0);

  AST_PTR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q[0] == 1'b0); // R2
  AST_PTR_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |=> sp_q == PTR_W'($past(sp_q) - STEP_V)); // R2
  AST_PTR_INC: assert property (@(posedge clk) disable iff (!rst_n)
    inc_en |=> sp_q == PTR_W'($past(sp_q) + STEP_V)); // R3
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_en && !inc_en) |=> $stable(sp_q)); // R6
endmodule

// File: rtl/stk_agen.sv
module stk_agen #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter int ADDR_W = 20
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] addr
);
  localparam int BASE_W = SEG_W + SHIFT;
  localparam int SUM_W  = ((BASE_W > OFF_W) ? BASE_W : OFF_W) + 1;

  logic [SUM_W-1:0] base_w;
  logic [SUM_W-1:0] sum_w;

  assign base_w = SUM_W'(seg) << SHIFT;
  assign sum_w  = base_w + SUM_W'(off);

  generate
    if (SUM_W >= ADDR_W) begin : g_trunc
      assign addr = sum_w[ADDR_W-1:0];
    end else begin : g_ext
      assign addr = ADDR_W'(sum_w);
    end
  endgenerate
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2,
  parameter int PTR_W = 16,
  parameter int SEG_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic                     cmd_op,
  input  logic [NBYTES*BYTE_W-1:0] cmd_data,
  input  logic [SEG_W-1:0]         seg_base,
  input  logic [PTR_W-1:0]         sp,
  input  logic                     at_empty,
  input  logic                     at_floor,
  output logic                     dec_en,
  output logic                     inc_en,
  output logic [SEG_W-1:0]         seg_cur,
  output logic [PTR_W-1:0]         off_cur,
  output logic                     mem_valid,
  input  logic                     mem_ready,
  output logic                     mem_we,
  output logic [BYTE_W-1:0]        mem_wdata,
  input  logic [BYTE_W-1:0]        mem_rdata,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [NBYTES*BYTE_W-1:0] rsp_data,
  output logic                     rsp_ovf,
  output logic                     rsp_unf,
  output logic                     busy
);
  localparam int WORD_W = NBYTES * BYTE_W;
  localparam int BEAT_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(NBYTES - 1);
  localparam logic [PTR_W-1:0] STEP_V = PTR_W'(NBYTES);

  stk_state_e        state_q;
  stk_op_e           op_q;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] rd_q;
  logic [SEG_W-1:0]  seg_q;
  logic [PTR_W-1:0]  off_q;
  logic [BEAT_W-1:0] beat_q;
  logic              ovf_q;
  logic              unf_q;
  logic              accept;
  logic              beat_done;

  assign cmd_ready = (state_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign mem_valid = (state_q == ST_XFER);
  assign beat_done = mem_valid && mem_ready;
  assign rsp_valid = (state_q == ST_RSP);
  assign busy      = (state_q != ST_IDLE);

  assign dec_en = accept && (cmd_op == OP_PUSH);
  assign inc_en = beat_done && (beat_q == LAST_BEAT) && (op_q == OP_POP);

  assign seg_cur   = seg_q;
  assign off_cur   = off_q + PTR_W'(beat_q);
  assign mem_we    = (op_q == OP_PUSH);
  assign mem_wdata = word_q[beat_q*BYTE_W +: BYTE_W];
  assign rsp_data  = (op_q == OP_POP) ? rd_q : word_q;
  assign rsp_ovf   = ovf_q;
  assign rsp_unf   = unf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_PUSH;
      word_q  <= '0;
      rd_q    <= '0;
      seg_q   <= '0;
      off_q   <= '0;
      beat_q  <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            op_q   <= stk_op_e'(cmd_op);
            word_q <= cmd_data;
            seg_q  <= seg_base;
            off_q  <= (cmd_op == OP_PUSH) ? (sp - STEP_V) : sp;
            ovf_q  <= (cmd_op == OP_PUSH) && at_floor;
            unf_q  <= (cmd_op == OP_POP) && at_empty;
            beat_q <= '0;
            state_q <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (mem_ready) begin
            if (op_q == OP_POP) begin
              rd_q[beat_q*BYTE_W +: BYTE_W] <= mem_rdata;
            end
            if (beat_q == LAST_BEAT) begin
              state_q <= ST_RSP;
            end else begin
              beat_q <= beat_q + 1'b1;
            end
          end
        end
        ST_RSP: begin
          if (rsp_ready) begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_BUSY_BLOCKS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready); // R6
  AST_FIRST_BEAT_AT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (mem_valid && off_cur == off_q)); // R4
  AST_NEXT_BYTE_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && beat_q != LAST_BEAT) |=> (mem_valid && off_cur == PTR_W'($past(off_cur) + 1'b1))); // R4
  AST_MEM_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(off_cur) && $stable(mem_we) && $stable(mem_wdata))); // R7
  AST_RSP_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_ovf) && $stable(rsp_unf))); // R8
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_ovf && rsp_unf)); // R10
endmodule

// File: rtl/stack_engine.sv
module stack_engine
  import stk_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2,
  parameter int PTR_W = 16,
  parameter int SEG_W = 16,
  parameter int SEG_SHIFT = 4,
  parameter int ADDR_W = 20,
  parameter logic [15:0] SP_INIT = 16'hFFFE
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SEG_W-1:0]         seg_base,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic                     cmd_op,
  input  logic [NBYTES*BYTE_W-1:0] cmd_data,
  output logic                     mem_valid,
  input  logic                     mem_ready,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [BYTE_W-1:0]        mem_wdata,
  input  logic [BYTE_W-1:0]        mem_rdata,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [NBYTES*BYTE_W-1:0] rsp_data,
  output logic                     rsp_ovf,
  output logic                     rsp_unf,
  output logic                     busy,
  output logic [PTR_W-1:0]         sp
);
  logic             dec_en;
  logic             inc_en;
  logic             at_empty;
  logic             at_floor;
  logic [SEG_W-1:0] seg_cur;
  logic [PTR_W-1:0] off_cur;

  stk_ptr #(
    .PTR_W(PTR_W), .STEP(NBYTES), .PTR_INIT(PTR_W'(SP_INIT))
  ) u_ptr (
    .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .inc_en(inc_en),
    .sp(sp), .at_empty(at_empty), .at_floor(at_floor)
  );

  stk_seq #(
    .BYTE_W(BYTE_W), .NBYTES(NBYTES), .PTR_W(PTR_W), .SEG_W(SEG_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .seg_base(seg_base), .sp(sp), .at_empty(at_empty), .at_floor(at_floor),
    .dec_en(dec_en), .inc_en(inc_en), .seg_cur(seg_cur), .off_cur(off_cur),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_ovf(rsp_ovf), .rsp_unf(rsp_unf), .busy(busy)
  );

  stk_agen #(
    .SEG_W(SEG_W), .OFF_W(PTR_W), .SHIFT(SEG_SHIFT), .ADDR_W(ADDR_W)
  ) u_agen (
    .seg(seg_cur), .off(off_cur), .addr(mem_addr)
  );

  AST_UNF_ON_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op && sp == PTR_W'(SP_INIT)) |=> rsp_unf); // R9
  AST_OVF_ON_FLOOR_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !cmd_op && sp == '0) |=> rsp_ovf); // R10
  AST_ADDR_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> $stable(mem_addr)); // R7
endmodule

// File: tb/test_stack_engine.sv
module test_stack_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] seg_base = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_op = 1'b0;
  logic [15:0] cmd_data = '0;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic        mem_we;
  logic [19:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [15:0] rsp_data;
  logic        rsp_ovf;
  logic        rsp_unf;
  logic        busy;
  logic [15:0] sp;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [15:0] m_sp;
  logic [7:0]  mem_m [bit [19:0]];

  always #10 clk = ~clk;

  stack_engine i_stack_engine (
    .clk(clk), .rst_n(rst_n), .seg_base(seg_base),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_ovf(rsp_ovf), .rsp_unf(rsp_unf), .busy(busy), .sp(sp)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] phys(input logic [15:0] seg, input logic [15:0] off);
    logic [20:0] s;
    s = {1'b0, seg, 4'h0} + {5'h0, off};
    return s[19:0];
  endfunction

  function automatic logic [7:0] mem_get(input logic [19:0] a);
    if (mem_m.exists(a)) return mem_m[a];
    return a[7:0] ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic do_op(input bit op, input logic [15:0] w, input logic [15:0] seg,
                       input int stall_pct);
    logic [15:0] off;
    logic [15:0] exp_word;
    bit exp_ovf;
    bit exp_unf;
    logic [19:0] a;
    logic [19:0] held_addr;
    logic [7:0]  held_wd;
    bit held;
    exp_ovf = (op == 1'b0) && (m_sp == 16'h0000);
    exp_unf = (op == 1'b1) && (m_sp == 16'hFFFE);
    off = op ? m_sp : m_sp - 16'd2;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = w; seg_base = seg;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    seg_base = $urandom;  // must not matter after acceptance, R5
    @(negedge clk);
    if (op == 1'b0) begin
      chk(sp == m_sp - 16'd2, "R2 sp after push accept", sp, m_sp - 16'd2);
      m_sp = m_sp - 16'd2;
    end
    exp_word = 16'h0;
    for (int b = 0; b < 2; b++) begin
      held = 1'b0;
      a = phys(seg, off + 16'(b));
      forever begin
        if (held && mem_valid) begin
          chk(mem_addr == held_addr && mem_wdata == held_wd, "R7 stall stability", mem_addr, held_addr);
        end
        chk(!cmd_ready && busy, "R6 busy blocks command", {cmd_ready, busy}, 2'b01);
        mem_ready = ($urandom % 100) >= stall_pct;
        mem_rdata = mem_get(mem_addr);
        if (mem_valid && mem_ready) begin
          chk(mem_addr == a, "R5 physical address", mem_addr, a);
          chk(mem_we == !op, "R4 write enable", mem_we, !op);
          if (op == 1'b0) begin
            chk(mem_wdata == w[b*8 +: 8], "R4 byte order", mem_wdata, w[b*8 +: 8]);
            mem_m[mem_addr] = mem_wdata;
          end else begin
            exp_word[b*8 +: 8] = mem_get(a);
          end
          @(posedge clk);
          #1 mem_ready = 1'b0;
          @(negedge clk);
          break;
        end
        held = mem_valid;
        held_addr = mem_addr;
        held_wd = mem_wdata;
        @(negedge clk);
      end
    end
    chk(!mem_valid, "R4 exactly two beats", mem_valid, 0);
    if (op == 1'b0) exp_word = w;
    forever begin
      rsp_ready = ($urandom % 100) >= stall_pct;
      if (rsp_valid) begin
        chk(rsp_data == exp_word, op ? "R3 popped word" : "R11 push echo", rsp_data, exp_word);
        chk(rsp_ovf == exp_ovf, "R10 overflow flag", rsp_ovf, exp_ovf);
        chk(rsp_unf == exp_unf, "R9 underflow flag", rsp_unf, exp_unf);
        if (rsp_ready) begin
          @(posedge clk);
          #1 rsp_ready = 1'b0;
          break;
        end else begin
          chk(!cmd_ready, "R8 response held blocks command", cmd_ready, 0);
        end
      end
      @(negedge clk);
    end
    if (op == 1'b1) m_sp = m_sp + 16'd2;
    @(negedge clk);
    chk(sp == m_sp, op ? "R3 sp after pop" : "R2 sp after push", sp, m_sp);
    chk(cmd_ready && !busy && !rsp_valid, "R6 idle after response", {cmd_ready, busy, rsp_valid}, 3'b100);
  endtask

  initial begin
    logic [15:0] seg;
    logic [15:0] vals [3];
    void'($urandom(32'd20240611));
    m_sp = 16'hFFFE;
    repeat (3) @(negedge clk);
    chk(sp == 16'hFFFE, "R1 reset pointer", sp, 16'hFFFE);
    chk(!busy && cmd_ready, "R1 reset ready", {busy, cmd_ready}, 2'b01);
    chk(!mem_valid && !rsp_valid, "R1 reset quiet", {mem_valid, rsp_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sp == 16'hFFFE, "R1 pointer after release", sp, 16'hFFFE);

    seg = 16'h1234;
    do_op(1'b1, 16'h0, seg, 30);              // R9 empty pop, wraps to 0000
    chk(m_sp == 16'h0000, "R9 wrap model", m_sp, 0);
    do_op(1'b0, 16'hBEEF, seg, 30);           // R10 push at floor, back to FFFE
    do_op(1'b1, 16'h0, 16'hFFFF, 0);          // R5 address truncation, R9 again
    do_op(1'b0, 16'h625A, 16'hFFFF, 50);      // R5 20-bit wrap on writes

    for (int i = 0; i < 3; i++) begin
      vals[i] = 16'h1111 * 16'(i + 1);
      do_op(1'b0, vals[i], seg, 0);
    end
    for (int i = 2; i >= 0; i--) begin
      do_op(1'b1, 16'h0, seg, 60);
      chk(rsp_data == vals[i], "R3 LIFO order", rsp_data, vals[i]);
    end

    for (int i = 0; i < 400; i++) begin
      bit op;
      op = ($urandom % 100) < 45;
      if (($urandom % 20) == 0) seg = $urandom;
      do_op(op, 16'($urandom), seg, $urandom % 70);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule